// File: doc/BRIEF.md
# Fixed-Priority Nested Interrupt Controller

This block gathers 32 external interrupt request lines and presents them to a single CPU as one request signal with a vector. The vector of every line is hard-wired: line i always reports vector 32+i, and a larger vector always wins. Interrupts nest. A request can only reach the CPU when it ranks above everything already in service. A request at the same or a lower rank waits as pending until software retires the top in-service interrupt with an end-of-interrupt (EOI) write.

Software configures the block through a small register bus. Each line has a two-bit entry holding a mask bit and a trigger-mode bit. These entries are reached indirectly: software first writes a line index to a select register, then reads or writes a window register, which makes read-modify-write of one entry possible. The bus also exposes a read-only in-service register and a write-only EOI register. A timer-route register lets an internal timer request take over one of lines 0 to 15. While that route is enabled, the pin of the chosen line is ignored.

The CPU side is a handshake. `int_req` is raised while an eligible request exists, and `int_vec` shows the vector of the winner. Pulsing `int_ack` while `int_req` is high moves the winning line from pending to in service at the next clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every line entry reads 1 through the window (masked, edge mode), the in-service register reads 0, the timer-route register reads 0x10 (routing disabled, line 0), and `int_req` is low.
- R2: Bus address 0 is the line select (data bits 4:0), and address 1 is the window onto the selected line's entry (bit 0 mask, 1 = masked; bit 1 trigger mode, 1 = level). A window write changes only the selected line, and the window reads back what was written.
- R3: A masked line never drives `int_req`, and edges that arrive while it is masked are not recorded.
- R4: When several lines are pending and eligible, `int_vec` equals 32 plus the highest pending line index.
- R5: `int_ack` while `int_req` is high sets in-service bit i for the winning line i, which is visible at address 2. An edge-mode line stays pending until it is acknowledged.
- R6: A pending request raises `int_req` only if its line index is above every in-service bit. A request from the in-service line itself or from a lower line does not raise it.
- R7: A write to address 3 (EOI) clears only the highest set in-service bit. The highest remaining eligible pending line is then requested.
- R8: An EOI write while the in-service register is zero changes neither the in-service register nor the pending requests.
- R9: In edge mode one rising edge creates exactly one request, and that request is held after the pin falls.
- R10: In level mode a line is pending while its pin is high and it is not in service. It is not pending once the pin is low. If the pin is still high after the EOI, it is requested again.
- R11: Address 4 is the timer route: bits 3:0 select the line and bit 4 disables routing (1 = disabled). When routing is enabled, a rising edge on `timer_req` requests the selected line. The pin, the mask bit and the trigger-mode bit of that line are ignored.
- R12: When an acknowledge and an EOI write fall in the same cycle, the EOI retires the previous top in-service bit and the acknowledged line is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | External request lines |
| timer_req | input | 1 | Internal timer request |
| bus_addr | input | 3 | Register address (0 select, 1 window, 2 in-service, 3 EOI, 4 timer route) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 5 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| int_req | output | 1 | Request to the CPU |
| int_ack | input | 1 | CPU acknowledge |
| int_vec | output | 8 | Vector of the current winner, 0 when no request |

## Verification
An acknowledge and an EOI write can land in the same clock edge, with the EOI working on the old in-service value while the acknowledge adds a new bit. The bench creates this by putting a low line in service, letting a higher line preempt, and then driving `int_ack` and the EOI write on the same negative edge. It judges the result by reading the in-service register: it must hold only the higher line's bit, and the lower bit must be retired. A second pairing is an edge on a line that arrives while that same line is in service. It must stay pending, with `int_req` low, until the EOI.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int VBASE = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] irq_in,
  input  logic        timer_req,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [4:0]  bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        int_req,
  input  logic        int_ack,
  output logic [7:0]  int_vec
);
  localparam logic [2:0] A_SEL = 3'd0, A_WIN = 3'd1, A_ISR = 3'd2, A_EOI = 3'd3, A_TMR = 3'd4;

  logic [4:0]  sel_q;
  logic [31:0] mask_q, lvl_q, epend_q, isr_q, prev_q;
  logic [3:0]  tline_q;
  logic        toff_q;

  function automatic logic [5:0] top_bit(input logic [31:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = 0; i < 32; i++)
      if (v[i]) r = {1'b1, 5'(i)};
    return r;
  endfunction

  logic [31:0] tsel, src, mask_eff, lvl_eff, rise, pend, ack_hot, eoi_hot;
  logic [5:0]  ptop, stop;
  logic        grant, eoi;

  assign tsel     = toff_q ? 32'h0 : (32'h1 << tline_q);
  assign src      = (irq_in & ~tsel) | ({32{timer_req}} & tsel);
  assign mask_eff = mask_q & ~tsel;
  assign lvl_eff  = lvl_q & ~tsel;
  assign rise     = src & ~prev_q;
  assign pend     = (epend_q | (src & lvl_eff & ~isr_q)) & ~mask_eff;
  assign ptop     = top_bit(pend);
  assign stop     = top_bit(isr_q);

  assign int_req  = ptop[5] && (!stop[5] || ptop[4:0] > stop[4:0]);
  assign int_vec  = int_req ? 8'(VBASE) + {3'b0, ptop[4:0]} : 8'h0;
  assign grant    = int_req && int_ack;
  assign eoi      = bus_wr && bus_addr == A_EOI;
  assign ack_hot  = grant ? (32'h1 << ptop[4:0]) : 32'h0;
  assign eoi_hot  = (eoi && stop[5]) ? (32'h1 << stop[4:0]) : 32'h0;

  always_comb begin
    case (bus_addr)
      A_SEL:   bus_rdata = {27'b0, sel_q};
      A_WIN:   bus_rdata = {30'b0, lvl_q[sel_q], mask_q[sel_q]};
      A_ISR:   bus_rdata = isr_q;
      A_TMR:   bus_rdata = {27'b0, toff_q, tline_q};
      default: bus_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      mask_q  <= '1;
      lvl_q   <= '0;
      epend_q <= '0;
      isr_q   <= '0;
      prev_q  <= '0;
      tline_q <= '0;
      toff_q  <= 1'b1;
    end else begin
      prev_q  <= src;
      epend_q <= (epend_q | (rise & ~lvl_eff)) & ~lvl_eff & ~mask_eff & ~ack_hot;
      isr_q   <= (isr_q & ~eoi_hot) | ack_hot;
      if (bus_wr) begin
        case (bus_addr)
          A_SEL: sel_q <= bus_wdata;
          A_WIN: begin
            mask_q[sel_q] <= bus_wdata[0];
            lvl_q[sel_q]  <= bus_wdata[1];
          end
          A_TMR: begin
            tline_q <= bus_wdata[3:0];
            toff_q  <= bus_wdata[4];
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> !mask_eff[int_vec[4:0]]);
  // R6
  above_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (isr_q >> int_vec[4:0]) == 32'h0);
  // R4
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> int_vec >= 8'(VBASE));
  // R5
  grant_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !eoi) |=> isr_q[$past(int_vec[4:0])] && $countones(isr_q) == $countones($past(isr_q)) + 1);
  // R7
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !grant && isr_q != 0) |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
  // R8
  eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !grant && isr_q == 0) |=> isr_q == 0);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, timer_req = 0, bus_wr = 0, int_ack = 0;
  logic [31:0] irq_in = '0;
  logic [2:0]  bus_addr = '0;
  logic [4:0]  bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        int_req;
  logic [7:0]  int_vec;
  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] d;

  prio_irq_ctrl i_prio_irq_ctrl (.clk, .rst_n, .irq_in, .timer_req, .bus_addr, .bus_wr,
    .bus_wdata, .bus_rdata, .int_req, .int_ack, .int_vec);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp=<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [4:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0; #1;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1 v = bus_rdata;
  endtask
  task automatic pulse(input logic [31:0] lines);
    @(negedge clk); irq_in = lines;
    @(negedge clk); irq_in = '0; #1;
  endtask
  task automatic tpulse();
    @(negedge clk); timer_req = 1;
    @(negedge clk); timer_req = 0; #1;
  endtask
  task automatic ack();
    @(negedge clk); int_ack = 1;
    @(negedge clk); int_ack = 0; #1;
  endtask
  task automatic eoi();
    wr(3'd3, 5'd0);
  endtask
  task automatic set_line(input int i, input logic [4:0] v);
    wr(3'd0, 5'(i)); wr(3'd1, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;

    // R1 reset state
    chk("R1 int_req", {31'b0, int_req}, 0);
    rd(3'd2, d); chk("R1 isr", d, 0);
    rd(3'd4, d); chk("R1 timer route", d, 32'h10);
    for (int i = 0; i < 32; i++) begin
      wr(3'd0, 5'(i)); rd(3'd1, d); chk("R1 entry masked", d, 1);
    end

    // R3 masked lines ignore edges
    pulse('1);
    chk("R3 masked no req", {31'b0, int_req}, 0);
    for (int i = 0; i < 32; i++) set_line(i, 5'd0);
    chk("R3 masked edges not kept", {31'b0, int_req}, 0);

    // R2 indirect access
    set_line(5, 5'd3);
    wr(3'd0, 5'd5); rd(3'd1, d); chk("R2 readback", d, 3);
    rd(3'd0, d); chk("R2 select readback", d, 5);
    wr(3'd0, 5'd4); rd(3'd1, d); chk("R2 neighbour low", d, 0);
    wr(3'd0, 5'd6); rd(3'd1, d); chk("R2 neighbour high", d, 0);
    set_line(5, 5'd0);

    // R9 R5 R7 single-line sweep
    for (int i = 0; i < 32; i++) begin
      pulse(32'h1 << i);
      chk("R9 edge req", {31'b0, int_req}, 1);
      chk("R4 vec", {24'b0, int_vec}, 32 + i);
      @(negedge clk); #1 chk("R9 held", {31'b0, int_req}, 1);
      ack();
      rd(3'd2, d); chk("R5 isr bit", d, 32'h1 << i);
      chk("R9 one request", {31'b0, int_req}, 0);
      eoi();
      rd(3'd2, d); chk("R7 isr cleared", d, 0);
    end

    // R4 R6 R7 all pairs arriving together
    for (int i = 0; i < 32; i++)
      for (int j = i + 1; j < 32; j++) begin
        pulse((32'h1 << i) | (32'h1 << j));
        chk("R4 pair winner", {24'b0, int_vec}, 32 + j);
        ack();
        chk("R6 lower held", {31'b0, int_req}, 0);
        eoi();
        chk("R7 next req", {24'b0, int_vec}, 32 + i);
        ack();
        rd(3'd2, d); chk("R5 isr lower", d, 32'h1 << i);
        eoi();
      end

    // R6 preemption and equal priority
    for (int i = 0; i < 31; i++) begin
      pulse(32'h1 << i); ack();
      pulse(32'h1 << i);
      chk("R6 equal no preempt", {31'b0, int_req}, 0);
      pulse(32'h1 << (i + 1));
      chk("R6 higher preempts", {24'b0, int_vec}, 33 + i);
      ack();
      rd(3'd2, d); chk("R6 nested isr", d, 32'h3 << i);
      eoi();
      rd(3'd2, d); chk("R7 top retired", d, 32'h1 << i);
      chk("R7 same-line waits", {31'b0, int_req}, 0);
      eoi();
      chk("R7 same-line requested", {24'b0, int_vec}, 32 + i);
      ack(); eoi();
    end

    // R8 idle EOI
    pulse(32'h8);
    eoi();
    chk("R8 pending kept", {24'b0, int_vec}, 35);
    rd(3'd2, d); chk("R8 isr zero", d, 0);
    ack(); eoi();

    // R10 level mode
    set_line(7, 5'd2);
    @(negedge clk); irq_in[7] = 1; #1;
    chk("R10 level req", {24'b0, int_vec}, 39);
    @(negedge clk); irq_in[7] = 0; #1;
    chk("R10 level drop", {31'b0, int_req}, 0);
    @(negedge clk); irq_in[7] = 1;
    ack();
    chk("R10 in service", {31'b0, int_req}, 0);
    eoi();
    chk("R10 re-request", {24'b0, int_vec}, 39);
    @(negedge clk); irq_in[7] = 0; #1;
    chk("R10 gone", {31'b0, int_req}, 0);
    set_line(7, 5'd0);

    // R11 timer routing
    for (int t = 0; t < 16; t++) begin
      if (t == 9) set_line(t, 5'd1);
      wr(3'd4, 5'(t));
      rd(3'd4, d); chk("R11 route readback", d, t);
      pulse(32'h1 << t);
      chk("R11 pin ignored", {31'b0, int_req}, 0);
      tpulse();
      chk("R11 timer vec", {24'b0, int_vec}, 32 + t);
      ack(); eoi();
      wr(3'd4, 5'(16 + t));
      tpulse();
      chk("R11 timer disabled", {31'b0, int_req}, 0);
      if (t == 9) set_line(t, 5'd0);
    end

    // R12 acknowledge and EOI together
    for (int i = 0; i < 16; i++) begin
      pulse(32'h1 << i); ack();
      pulse(32'h1 << (i + 16));
      chk("R12 preempt req", {24'b0, int_vec}, 48 + i);
      @(negedge clk); int_ack = 1; bus_addr = 3'd3; bus_wr = 1;
      @(negedge clk); int_ack = 0; bus_wr = 0; #1;
      rd(3'd2, d); chk("R12 isr swap", d, 32'h1 << (i + 16));
      eoi();
      rd(3'd2, d); chk("R12 isr empty", d, 0);
    end

    finish_run();
  end
endmodule